// File: doc/BRIEF.md
# Single-Wire Echoing Serial Monitor

This block is a half-duplex serial monitor that talks to a host over one bidirectional pin. Frames are asynchronous NRZ: a low start bit, eight data bits least significant first, and a high stop bit. Transmit and receive share one bit time, set in clock cycles by `CLKS_PER_BIT`. The default suits 28.8 kBaud on a fast core clock.

Each byte the block receives is sent straight back on the same pin, so the host can check it. A read command has three bytes: the opcode `READ_OP`, then the address high byte, then the address low byte. After the third echo has finished, the block issues one read strobe on a synchronous memory port. It then transmits the returned byte.

When the line stays low for a start bit plus nine more bit times, the block treats it as a break. It waits for the host to release the line, drives the pin high for two bit times, and then sends a zero-valued frame. The pin is released whenever the block is not transmitting, and a pull-up holds it high.

Top module: `swire_monitor`

## Requirements
- R1: During and right after reset the pin is released (reads high through the pull-up) and `mem_rd` is low.
- R2: Every frame the block sends has a low start bit, eight data bits LSB first, and a high stop bit. Each bit lasts `CLKS_PER_BIT` cycles, and the pin is released after the stop bit.
- R3: Every byte received with a high stop bit is echoed unchanged. The echo start bit begins between 9*`CLKS_PER_BIT`+`CLKS_PER_BIT`/2 and that value plus 5 cycles after the host's start edge.
- R4: A byte that arrives while an opcode is expected and does not equal `READ_OP` is echoed and nothing else happens. There is no memory read and no further frame.
- R5: After the echo of the address low byte of a read command, `mem_rd` pulses high for exactly one cycle. During that cycle `mem_addr` holds {high byte, low byte}. No strobe happens while the block drives the pin.
- R6: The byte that the memory returns on the cycle after the strobe is sent as a frame. Its start bit begins 10*`CLKS_PER_BIT` to 10*`CLKS_PER_BIT`+4 cycles after the start of the last echo.
- R7: A break (start bit plus nine further low bit times) is answered once the host releases the line. The pin stays high for two bit times, and then a zero-valued frame follows. The start bit of that frame comes 2*`CLKS_PER_BIT` to 2*`CLKS_PER_BIT`+5 cycles after the release.
- R8: A break discards a partly received read command, so the bytes that follow are parsed from the opcode position.
- R9: A frame with a low stop bit and non-zero data is dropped without any echo.
- R10: A low pulse shorter than half a bit time is not taken as a start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin | inout | 1 | Shared serial line, released when idle |
| mem_addr | output | 16 | Read address |
| mem_rd | output | 1 | One-cycle read strobe |
| mem_data | input | 8 | Read data, valid the cycle after the strobe |

## Verification
The bench builds the block with 8 cycles per bit and opcode 0x4A. At that speed a frame takes 80 cycles, which makes a full sweep practical. Every byte value except the opcode is sent as an ignored opcode and its echo is checked, and about seventy read transactions cover spread addresses, 0x0000, 0xFFFF and the opcode value used as an address byte. The short bit time also lets the bench check echo, result and break timing to within a few cycles. Breaks, frames with a low stop bit and sub-half-bit glitches are each placed between normal traffic.

// File: rtl/swire_monitor.sv
module swire_monitor #(
  parameter int       CLKS_PER_BIT = 4340,
  parameter bit [7:0] READ_OP      = 8'h4A
) (
  input  logic        clk,
  input  logic        rst_n,
  inout  wire         pin,
  output logic [15:0] mem_addr,
  output logic        mem_rd,
  input  logic [7:0]  mem_data
);
  localparam int CW   = $clog2(CLKS_PER_BIT);
  localparam int HALF = CLKS_PER_BIT / 2;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_DATA, S_STOP, S_FLUSH,
    S_BRKW, S_BRKHI, S_TX, S_MRD, S_MCAP
  } st_t;
  typedef enum logic [1:0] {C_OP, C_HI, C_LO} cmd_t;

  st_t         st;
  cmd_t        cmd;
  logic [CW-1:0] cnt;
  logic [3:0]  bitn;
  logic [7:0]  rx_sh;
  logic [9:0]  tx_sh;
  logic        drv_en, is_res, is_brk, s1, s2;

  wire cnt_last  = (cnt == CW'(CLKS_PER_BIT - 1));
  wire half_last = (cnt == CW'(HALF - 1));

  assign pin    = drv_en ? tx_sh[0] : 1'bz;
  assign mem_rd = (st == S_MRD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cmd      <= C_OP;
      cnt      <= '0;
      bitn     <= '0;
      rx_sh    <= '0;
      tx_sh    <= '1;
      drv_en   <= 1'b0;
      is_res   <= 1'b0;
      is_brk   <= 1'b0;
      mem_addr <= '0;
      s1       <= 1'b1;
      s2       <= 1'b1;
    end else begin
      s1 <= pin;
      s2 <= s1;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (!s2) st <= S_START;
        end
        S_START:
          if (half_last) begin
            cnt  <= '0;
            bitn <= '0;
            st   <= s2 ? S_IDLE : S_DATA;
          end else cnt <= cnt + 1'b1;
        S_DATA:
          if (cnt_last) begin
            cnt   <= '0;
            rx_sh <= {s2, rx_sh[7:1]};
            bitn  <= bitn + 1'b1;
            if (bitn == 4'd7) st <= S_STOP;
          end else cnt <= cnt + 1'b1;
        S_STOP:
          if (cnt_last) begin
            cnt  <= '0;
            bitn <= '0;
            if (s2) begin
              tx_sh  <= {1'b1, rx_sh, 1'b0};
              drv_en <= 1'b1;
              is_res <= 1'b0;
              is_brk <= 1'b0;
              st     <= S_TX;
            end else if (rx_sh == 8'h00) st <= S_BRKW;
            else st <= S_FLUSH;
          end else cnt <= cnt + 1'b1;
        S_FLUSH: begin
          cmd <= C_OP;
          if (s2) st <= S_IDLE;
        end
        S_BRKW:
          if (s2) begin
            cmd    <= C_OP;
            cnt    <= '0;
            bitn   <= '0;
            tx_sh  <= '1;
            drv_en <= 1'b1;
            st     <= S_BRKHI;
          end
        S_BRKHI:
          if (cnt_last) begin
            cnt  <= '0;
            bitn <= bitn + 1'b1;
            if (bitn == 4'd1) begin
              bitn   <= '0;
              tx_sh  <= {1'b1, 8'h00, 1'b0};
              is_brk <= 1'b1;
              is_res <= 1'b0;
              st     <= S_TX;
            end
          end else cnt <= cnt + 1'b1;
        S_TX:
          if (cnt_last) begin
            cnt   <= '0;
            tx_sh <= {1'b1, tx_sh[9:1]};
            bitn  <= bitn + 1'b1;
            if (bitn == 4'd9) begin
              bitn   <= '0;
              drv_en <= 1'b0;
              st     <= S_IDLE;
              if (is_res || is_brk) cmd <= C_OP;
              else begin
                case (cmd)
                  C_OP: if (rx_sh == READ_OP) cmd <= C_HI;
                  C_HI: begin
                    mem_addr[15:8] <= rx_sh;
                    cmd            <= C_LO;
                  end
                  C_LO: begin
                    mem_addr[7:0] <= rx_sh;
                    cmd           <= C_OP;
                    st            <= S_MRD;
                  end
                  default: cmd <= C_OP;
                endcase
              end
            end
          end else cnt <= cnt + 1'b1;
        S_MRD: st <= S_MCAP;
        S_MCAP: begin
          tx_sh  <= {1'b1, mem_data, 1'b0};
          drv_en <= 1'b1;
          is_res <= 1'b1;
          is_brk <= 1'b0;
          cnt    <= '0;
          bitn   <= '0;
          st     <= S_TX;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module swire_monitor_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pin,
  input logic        mem_rd,
  input logic [15:0] mem_addr,
  input logic        drv_en
);
  // R1
  reset_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!drv_en && !mem_rd));

  // R5
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  // R5
  strobe_quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !drv_en);

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> $stable(mem_addr));

  // R2
  stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_en) |-> $past(pin) == 1'b1);
endmodule

bind swire_monitor swire_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pin(pin),
  .mem_rd(mem_rd), .mem_addr(mem_addr), .drv_en(drv_en)
);

// File: tb/swire_monitor_tb.sv
`timescale 1ns/1ps
module swire_monitor_tb;
  localparam int       C    = 8;
  localparam int       HALF = C / 2;
  localparam bit [7:0] OP   = 8'h4A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_low = 1'b0;
  wire  pin;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_q = 8'h00;

  int cyc = 0, nchk = 0, nfail = 0, rd_cnt = 0;
  logic [15:0] last_addr = 16'h0;
  bit done = 0;

  assign pin = host_low ? 1'b0 : 1'bz;
  pullup (pin);

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] mfn(input logic [15:0] a);
    logic [7:0] t;
    t = a[15:8] * 8'd7 + a[7:0];
    return t ^ 8'h5C;
  endfunction

  always @(posedge clk) if (mem_rd) begin
    mem_q     <= mfn(mem_addr);
    last_addr <= mem_addr;
    rd_cnt    <= rd_cnt + 1;
  end

  swire_monitor #(.CLKS_PER_BIT(C), .READ_OP(OP)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin(pin),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_data(mem_q)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int t_start, t_rel;

  task automatic send(input logic [7:0] b, input bit stop_low);
    @(negedge clk);
    t_start = cyc;
    host_low = 1'b1;
    repeat (C) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      host_low = ~b[i];
      repeat (C) @(negedge clk);
    end
    host_low = stop_low;
    if (stop_low) begin
      repeat (C) @(negedge clk);
      host_low = 1'b0;
    end
  endtask

  task automatic get_frame(input int limit, output bit got, output logic [7:0] b,
                           output bit stp, output int fall);
    got = 0; b = 8'h00; stp = 0; fall = 0;
    for (int n = 0; n < limit && !got; n++) begin
      @(negedge clk);
      if (pin == 1'b0) begin got = 1; fall = cyc; end
    end
    if (got) begin
      for (int k = 1; k <= 9; k++) begin
        while (cyc < fall + HALF + k * C) @(negedge clk);
        if (k <= 8) b[k-1] = pin;
        else stp = pin;
      end
      repeat (HALF + 1) @(negedge clk);
    end
  endtask

  task automatic echo_byte(input logic [7:0] v, input string tag, output int fall);
    bit got, stp;
    logic [7:0] b;
    send(v, 1'b0);
    get_frame(14 * C, got, b, stp, fall);
    chk(got, {tag, " echo present"}, got, 1);
    chk(b == v, {tag, " echo data"}, b, v);
    chk(stp == 1'b1, "R2 stop bit high", stp, 1);
    chk(fall - t_start >= 9 * C + HALF && fall - t_start <= 9 * C + HALF + 5,
        "R3 echo start time", fall - t_start, 9 * C + HALF);
  endtask

  task automatic no_frame(input int win, input string tag);
    bit got, stp;
    logic [7:0] b;
    int f;
    get_frame(win, got, b, stp, f);
    chk(!got, tag, got, 0);
  endtask

  task automatic do_read(input logic [15:0] a);
    int f, rb;
    bit got, stp;
    logic [7:0] b;
    rb = rd_cnt;
    echo_byte(OP, "R5 opcode", f);
    echo_byte(a[15:8], "R5 addr hi", f);
    echo_byte(a[7:0], "R5 addr lo", f);
    get_frame(12 * C, got, b, stp, f);
    chk(got, "R6 result present", got, 1);
    chk(b == mfn(a), "R6 result data", b, mfn(a));
    chk(stp, "R2 result stop", stp, 1);
    chk(rd_cnt == rb + 1, "R5 one strobe", rd_cnt - rb, 1);
    chk(last_addr == a, "R5 strobe address", last_addr, a);
  endtask

  task automatic do_break(input string tag);
    bit got, stp;
    logic [7:0] b;
    int f;
    @(negedge clk);
    host_low = 1'b1;
    repeat (10 * C) @(negedge clk);
    host_low = 1'b0;
    t_rel = cyc;
    get_frame(4 * C, got, b, stp, f);
    chk(got, {tag, " break answer"}, got, 1);
    chk(f - t_rel >= 2 * C && f - t_rel <= 2 * C + 5, "R7 high interval", f - t_rel, 2 * C);
    chk(b == 8'h00 && stp, "R7 zero frame", b, 0);
  endtask

  initial begin
    int f, rb;
    repeat (5) @(negedge clk);
    chk(pin == 1'b1, "R1 pin released in reset", pin, 1);
    chk(mem_rd == 1'b0, "R1 no strobe in reset", mem_rd, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(pin == 1'b1 && mem_rd == 1'b0, "R1 idle after reset", pin, 1);

    rb = rd_cnt;
    for (int v = 0; v < 256; v++) begin
      if (v[7:0] == OP) continue;
      echo_byte(v[7:0], "R4 ignored opcode", f);
      if (v % 32 == 0) no_frame(3 * C, "R4 no frame after ignored byte");
    end
    chk(rd_cnt == rb, "R4 no memory read", rd_cnt - rb, 0);

    do_read(16'h0000);
    do_read(16'hFFFF);
    do_read({OP, OP});
    for (int i = 0; i < 64; i++) do_read(16'(i * 16'h0403 + 16'h1357));

    do_break("R7");
    do_read(16'hA5C3);

    rb = rd_cnt;
    echo_byte(OP, "R8 opcode", f);
    echo_byte(8'h12, "R8 addr hi", f);
    do_break("R8");
    echo_byte(8'h34, "R8 byte after break", f);
    no_frame(12 * C, "R8 no result after break");
    chk(rd_cnt == rb, "R8 no strobe", rd_cnt - rb, 0);
    do_read(16'h1234);

    send(8'h55, 1'b1);
    no_frame(12 * C, "R9 no echo of framing error");
    echo_byte(8'h3C, "R9 recovery", f);

    @(negedge clk);
    host_low = 1'b1;
    repeat (2) @(negedge clk);
    host_low = 1'b0;
    no_frame(14 * C, "R10 glitch ignored");
    echo_byte(8'hC3, "R10 recovery", f);
    do_read(16'h8001);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule